// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the configuration space of a host bridge target: an array of 256 bytes that an upstream decoder reaches with one access per cycle. Each access names a byte offset, a length in bytes and a direction. The block stores or returns that many consecutive bytes, little-endian: the byte at the lowest offset sits in the least significant byte of the data word.

Two offsets are protected, and a write never changes them, though the other bytes of the same access are still written. A power-on reset clears the whole array. A separate synchronous header reset loads fixed values into three header bytes and leaves every other byte as it is.

A write takes effect at the clock edge that accepts it. Read data is registered. It appears one cycle after the request, together with a single-cycle valid pulse, and it is held until the next read.

Top module: `hb_cfg_regfile`

## Requirements
- R1: While `por_n` is low, every byte of the array is cleared to 0x00, `rd_valid_o` is low and `rd_data_o` is 0.
- R2: A read (`req_valid_i`=1, `req_write_i`=0) with `req_len_i` of 1 to 4 returns, one cycle later, byte offset+i in `rd_data_o[8i+7:8i]` for each i below the length, with the unused upper bytes at 0x00. A read changes no stored byte.
- R3: A read with `req_len_i` of 5, 6 or 7 returns 0xFFFFFFFF. A read with `req_len_i` of 0 returns 0x00000000.
- R4: A write (`req_write_i`=1) with `req_len_i` of 1 to 4 stores `req_wdata_i[8i+7:8i]` into byte offset+i for each i below the length.
- R5: Bytes 0x06 and 0x0C never take a write value. Every other byte covered by the same write is still updated.
- R6: A write with `req_len_i` of 0, 5, 6 or 7 changes no byte.
- R7: Byte addresses offset+i wrap modulo 256, for reads and for writes.
- R8: When `hdr_rst_i` is high at a clock edge, byte 0x04 becomes 0x06, byte 0x05 becomes 0x00 and byte 0x06 becomes 0x80. Every other byte keeps its value, and any request in that cycle is dropped, with no read pulse.
- R9: `rd_valid_o` is high for exactly the one cycle after each accepted read, and low after writes and idle cycles. `rd_data_o` holds its last read value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears the whole array |
| hdr_rst_i | input | 1 | Synchronous header reset; loads the three header defaults |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 8 | Byte offset of the first byte |
| req_len_i | input | 3 | Number of bytes; 1 to 4 are valid lengths |
| req_wdata_i | input | 32 | Write data, lowest byte goes to the offset |
| rd_valid_o | output | 1 | One-cycle pulse when read data is presented |
| rd_data_o | output | 32 | Assembled read data |

## Verification
The bench first fills the array with one distinct byte per offset. It then reads every offset with every length code from 0 to 7, so each case is tried: the four valid lengths, the all-ones result for oversized lengths, the zero result for length 0, and the wrap from byte 0xFF to 0x00. A second fill uses mixed lengths at every offset, so overlapping multi-byte writes that cross the protected bytes and the top of the array are checked against byte-by-byte expectations. Writes with invalid lengths and header resets applied over non-zero contents then show which bytes must move and which must stay.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

    // header bytes loaded by the synchronous header reset
    localparam int unsigned HDR_CMD_LO  = 32'h04;
    localparam int unsigned HDR_CMD_HI  = 32'h05;
    localparam int unsigned HDR_STAT_LO = 32'h06;

    localparam logic [7:0] HDR_CMD_LO_RV  = 8'h06;
    localparam logic [7:0] HDR_CMD_HI_RV  = 8'h00;
    localparam logic [7:0] HDR_STAT_LO_RV = 8'h80;

    // offsets that never accept write data
    localparam int unsigned LOCK_A = 32'h06;
    localparam int unsigned LOCK_B = 32'h0C;

    function automatic logic is_locked(input int unsigned byte_idx);
        return (byte_idx == LOCK_A) || (byte_idx == LOCK_B);
    endfunction

endpackage

// File: rtl/hb_cfg_lane_map.sv
module hb_cfg_lane_map #(
    parameter int unsigned OFF_W = 8,
    parameter int unsigned LEN_W = 3,
    parameter int unsigned LANES = 4
) (
    input  logic [OFF_W-1:0]             off_i,
    input  logic [LEN_W-1:0]             len_i,
    output logic [LANES-1:0][OFF_W-1:0]  idx_o,
    output logic [LANES-1:0]             lane_on_o,
    output logic [LANES-1:0]             wr_keep_o,
    output logic                         over_o
);
    import hb_cfg_pkg::*;

    logic len_ok;
    assign len_ok = (len_i <= LEN_W'(LANES));
    assign over_o = ~len_ok;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // natural truncation to OFF_W bits gives the modulo wrap
        assign idx_o[k]     = off_i + OFF_W'(k);
        assign lane_on_o[k] = len_ok && (LEN_W'(k) < len_i);
        assign wr_keep_o[k] = lane_on_o[k] && !is_locked(32'(idx_o[k]));
    end

endmodule

// File: rtl/hb_cfg_rd_pack.sv
module hb_cfg_rd_pack #(
    parameter int unsigned NUM_BYTES = 256,
    parameter int unsigned OFF_W     = 8,
    parameter int unsigned LANES     = 4
) (
    input  logic [NUM_BYTES-1:0][7:0]    mem_i,
    input  logic [LANES-1:0][OFF_W-1:0]  idx_i,
    input  logic [LANES-1:0]             lane_on_i,
    input  logic                         over_i,
    output logic [LANES*8-1:0]           data_o
);
    logic [LANES-1:0][7:0] lane_byte;

    for (genvar k = 0; k < LANES; k++) begin : g_pick
        assign lane_byte[k] = lane_on_i[k] ? mem_i[idx_i[k]] : 8'h00;
    end

    assign data_o = over_i ? {(LANES*8){1'b1}} : lane_byte;

endmodule

// File: rtl/hb_cfg_regfile.sv
module hb_cfg_regfile #(
    parameter int unsigned NUM_BYTES = 256,
    parameter int unsigned LANES     = 4
) (
    input  logic                              clk,
    input  logic                              por_n,
    input  logic                              hdr_rst_i,
    input  logic                              req_valid_i,
    input  logic                              req_write_i,
    input  logic [$clog2(NUM_BYTES)-1:0]      req_off_i,
    input  logic [$clog2(2*LANES)-1:0]        req_len_i,
    input  logic [LANES*8-1:0]                req_wdata_i,
    output logic                              rd_valid_o,
    output logic [LANES*8-1:0]                rd_data_o
);
    import hb_cfg_pkg::*;

    localparam int unsigned OFF_W = $clog2(NUM_BYTES);
    localparam int unsigned LEN_W = $clog2(2*LANES);
    localparam int unsigned DW    = LANES*8;

    typedef struct packed {
        logic [NUM_BYTES-1:0][7:0] mem;
        logic                      rvld;
        logic [DW-1:0]             rdat;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0][OFF_W-1:0] idx;
    logic [LANES-1:0]            lane_on;
    logic [LANES-1:0]            wr_keep;
    logic                        over;
    logic [DW-1:0]               rd_word;

    hb_cfg_lane_map #(
        .OFF_W (OFF_W),
        .LEN_W (LEN_W),
        .LANES (LANES)
    ) u_map (
        .off_i     (req_off_i),
        .len_i     (req_len_i),
        .idx_o     (idx),
        .lane_on_o (lane_on),
        .wr_keep_o (wr_keep),
        .over_o    (over)
    );

    hb_cfg_rd_pack #(
        .NUM_BYTES (NUM_BYTES),
        .OFF_W     (OFF_W),
        .LANES     (LANES)
    ) u_pack (
        .mem_i     (st_q.mem),
        .idx_i     (idx),
        .lane_on_i (lane_on),
        .over_i    (over),
        .data_o    (rd_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rvld = 1'b0;
        if (hdr_rst_i) begin
            st_d.mem[HDR_CMD_LO]  = HDR_CMD_LO_RV;
            st_d.mem[HDR_CMD_HI]  = HDR_CMD_HI_RV;
            st_d.mem[HDR_STAT_LO] = HDR_STAT_LO_RV;
        end else if (req_valid_i) begin
            if (req_write_i) begin
                for (int k = 0; k < LANES; k++) begin
                    if (wr_keep[k]) begin
                        st_d.mem[idx[k]] = req_wdata_i[8*k +: 8];
                    end
                end
            end else begin
                st_d.rvld = 1'b1;
                st_d.rdat = rd_word;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid_o = st_q.rvld;
    assign rd_data_o  = st_q.rdat;

    logic rd_req;
    assign rd_req = req_valid_i && !req_write_i && !hdr_rst_i;

    assert_hdr_defaults_R8: assert property (@(posedge clk) disable iff (!por_n)
        hdr_rst_i |=> (st_q.mem[HDR_CMD_LO] == HDR_CMD_LO_RV) &&
                      (st_q.mem[HDR_CMD_HI] == HDR_CMD_HI_RV) &&
                      (st_q.mem[HDR_STAT_LO] == HDR_STAT_LO_RV));

    assert_lock_b_R5: assert property (@(posedge clk) disable iff (!por_n)
        !hdr_rst_i |=> (st_q.mem[LOCK_B] == $past(st_q.mem[LOCK_B])));

    assert_lock_a_R5: assert property (@(posedge clk) disable iff (!por_n)
        !hdr_rst_i |=> (st_q.mem[LOCK_A] == $past(st_q.mem[LOCK_A])));

    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!por_n)
        rd_req |=> rd_valid_o);

    assert_no_pulse_R9: assert property (@(posedge clk) disable iff (!por_n)
        !rd_req |=> !rd_valid_o && $stable(rd_data_o));

    assert_long_rd_R3: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && (req_len_i > LEN_W'(LANES))) |=> (rd_data_o == {DW{1'b1}}));

    assert_rd_no_touch_R2: assert property (@(posedge clk) disable iff (!por_n)
        rd_req |=> $stable(st_q.mem));

    assert_bad_len_wr_R6: assert property (@(posedge clk) disable iff (!por_n)
        (req_valid_i && req_write_i && !hdr_rst_i &&
         ((req_len_i == '0) || (req_len_i > LEN_W'(LANES)))) |=> $stable(st_q.mem));

endmodule

// File: tb/sim_hb_cfg_regfile.sv
module sim_hb_cfg_regfile;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        hdr_rst = 1'b0;
    logic        rv = 1'b0;
    logic        rw = 1'b0;
    logic [7:0]  roff = '0;
    logic [2:0]  rlen = '0;
    logic [31:0] wd = '0;
    logic        vld;
    logic [31:0] rdata;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [7:0]  m [256];

    hb_cfg_regfile u0 (
        .clk         (clk),
        .por_n       (por_n),
        .hdr_rst_i   (hdr_rst),
        .req_valid_i (rv),
        .req_write_i (rw),
        .req_off_i   (roff),
        .req_len_i   (rlen),
        .req_wdata_i (wd),
        .rd_valid_o  (vld),
        .rd_data_o   (rdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [7:0] o, input int l);
        logic [31:0] r = '0;
        if (l > 4) return 32'hFFFF_FFFF;
        for (int k = 0; k < l; k++) r[8*k +: 8] = m[8'(o + 8'(k))];
        return r;
    endfunction

    function automatic string auto_tag(input int o, input int l);
        if (l == 0 || l > 4) return "R3";
        if (o + l > 256) return "R7";
        return "R2";
    endfunction

    task automatic do_write(input logic [7:0] o, input int l, input logic [31:0] d);
        @(negedge clk);
        rv = 1'b1; rw = 1'b1; roff = o; rlen = 3'(l); wd = d;
        @(negedge clk);
        rv = 1'b0; rw = 1'b0;
        if (l >= 1 && l <= 4)
            for (int k = 0; k < l; k++) begin
                logic [7:0] a = 8'(o + 8'(k));
                if (a != 8'h06 && a != 8'h0C) m[a] = d[8*k +: 8];
            end
    endtask

    task automatic do_read(input logic [7:0] o, input int l, input string tag);
        @(negedge clk);
        rv = 1'b1; rw = 1'b0; roff = o; rlen = 3'(l);
        @(negedge clk);
        rv = 1'b0;
        chk({tag, " valid"}, {31'b0, vld}, 32'd1);
        chk(tag, rdata, model_rd(o, l));
    endtask

    task automatic sweep(input string forced);
        for (int o = 0; o < 256; o++)
            for (int l = 0; l < 8; l++)
                do_read(8'(o), l, (forced != "") ? forced : auto_tag(o, l));
    endtask

    task automatic pulse_hdr_rst(input logic with_read);
        @(negedge clk);
        hdr_rst = 1'b1; rv = with_read; rw = 1'b0; roff = 8'h04; rlen = 3'd4;
        @(negedge clk);
        hdr_rst = 1'b0; rv = 1'b0;
        chk("R8 no read pulse", {31'b0, vld}, 32'd0);
        m[8'h04] = 8'h06; m[8'h05] = 8'h00; m[8'h06] = 8'h80;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] held;
        for (int a = 0; a < 256; a++) m[a] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {31'b0, vld}, 32'd0);
        chk("R1 reset data", rdata, 32'd0);
        por_n = 1'b1;

        // power-on contents are all zero
        sweep("R1");

        // header reset, with a read request in the same cycle
        pulse_hdr_rst(1'b1);
        do_read(8'h04, 4, "R8");
        chk("R8 direct", model_rd(8'h04, 4), 32'h0080_0006);

        // byte fill
        for (int a = 0; a < 256; a++) do_write(8'(a), 1, {24'h0, 8'(a * 29 + 7) ^ 8'h5A});
        do_read(8'h06, 1, "R5");
        chk("R5 lock6", rdata, 32'h0000_0080);
        do_read(8'h0C, 1, "R5");
        chk("R5 lockC", rdata, 32'h0000_0000);
        do_read(8'h10, 1, "R4");
        chk("R4 byte", rdata, {24'h0, 8'(16 * 29 + 7) ^ 8'h5A});
        sweep("");

        // mixed-length fill, overlapping, crossing locks and the wrap
        for (int a = 0; a < 256; a++)
            do_write(8'(a), (a % 4) + 1, {8'(a + 3), 8'(a) ^ 8'hA5, ~8'(a), 8'(a)});
        do_write(8'h04, 4, 32'hDEAD_BEEF);
        do_read(8'h04, 4, "R5");
        chk("R5 word", rdata, {8'hDE, 8'h80, 8'hBE, 8'hEF});
        do_write(8'hFE, 4, 32'h4433_2211);
        do_read(8'hFE, 4, "R7");
        chk("R7 wrap", rdata, 32'h4433_2211);
        sweep("");

        // writes with invalid lengths change nothing
        do_write(8'h20, 0, 32'h1234_5678);
        do_write(8'h21, 5, 32'h1234_5678);
        do_write(8'h22, 6, 32'h1234_5678);
        do_write(8'hFF, 7, 32'h1234_5678);
        for (int o = 8'h1C; o < 8'h28; o++) do_read(8'(o), 4, "R6");
        do_read(8'hFF, 2, "R6");

        // header reset over non-zero contents
        pulse_hdr_rst(1'b0);
        do_read(8'h04, 4, "R8");
        do_read(8'h10, 4, "R8");
        sweep("");

        // valid pulse and held data
        do_read(8'h30, 4, "R9");
        held = rdata;
        @(negedge clk);
        chk("R9 idle valid", {31'b0, vld}, 32'd0);
        chk("R9 held data", rdata, held);
        do_write(8'h40, 2, 32'h0000_ABCD);
        chk("R9 write valid", {31'b0, vld}, 32'd0);
        chk("R9 write held", rdata, held);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule